// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the processor-side steps once an interrupt has been accepted upstream. A pending request is held until the core signals an instruction boundary, so no instruction is ever cut in half. On that boundary the event code is written into a pair of event registers. The live status word and program counter are saved into their shadow registers. A new status word is formed with the block, privilege and bank-select bits forced to one, and the jump target is computed as the vector base plus a fixed offset of 0x600.

All of these registers load on one clock edge. A one-cycle redirect strobe is raised in the cycle that follows. The core uses that strobe to write the new status word back and fetch from the new target at once, with no delay slot. A request that arrives while the live status word has its block bit set is ignored.

The state machine has three states:
- `ST_IDLE`: no request held.
- `ST_PEND`: a request is held while the core waits for a boundary.
- `ST_ENTER`: the redirect cycle.

Its transitions are:
- `take`: from IDLE or PEND to ENTER, when a request is present, blocking is clear and the boundary strobe is high.
- `hold`: from IDLE to PEND, or PEND to PEND, when a request is present and not blocked but there is no boundary.
- `drop`: from PEND to IDLE, when the request is withdrawn or becomes blocked.
- `done`: from ENTER to IDLE, unconditionally.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, `redirect` is 0 and every output register (`sr_out`, `ssr`, `spc`, `evt_a`, `evt_b`, `pc_new`) reads 0.
- R2: An interrupt is taken only on a cycle with `insn_boundary` high. A request without a boundary stays pending and produces no redirect.
- R3: On entry, both `evt_a` and `evt_b` hold the `irq_code` value present on the boundary cycle.
- R4: On entry, `ssr` holds the `sr_in` value and `spc` holds the `pc_in` value present on the boundary cycle.
- R5: On entry, `sr_out` equals that `sr_in` with bits 30, 29 and 28 forced to 1. All other bits are unchanged, including the interrupt mask in bits 7:4.
- R6: On entry, `pc_new` equals `vbr_in + 0x00000600` (modulo 2^32), where `vbr_in` is the value on the boundary cycle.
- R7: `redirect` is high for exactly one cycle, the cycle after the boundary edge. All output registers change only on that same edge and hold otherwise.
- R8: While `sr_in[28]` is 1, a request is ignored: no redirect occurs and no output register changes.
- R9: A pending request withdrawn before a boundary arrives is discarded: a later boundary without a request causes no redirect.
- R10: A request present during the redirect cycle is not taken in that cycle. `redirect` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Accepted interrupt request from the controller |
| irq_code | input | 12 | Event code of the request |
| insn_boundary | input | 1 | High on cycles that end an instruction |
| sr_in | input | 32 | Live status register |
| pc_in | input | 32 | Program counter of the next instruction |
| vbr_in | input | 32 | Vector base register |
| sr_out | output | 32 | New status word to write back |
| ssr | output | 32 | Saved status register |
| spc | output | 32 | Saved program counter |
| evt_a | output | 12 | First event register |
| evt_b | output | 12 | Second event register |
| pc_new | output | 32 | Handler entry address |
| redirect | output | 1 | One-cycle strobe: load `sr_out` and fetch from `pc_new` |

## Verification
The hardest case to reach is a request that is still asserted during the redirect cycle itself. The core has not yet written back the block bit, so nothing in the live status word stops a second entry. The bench holds the request and the boundary high across consecutive cycles with the block bit clear. It changes the event code during the redirect cycle, which exposes both a missing guard state and a load on the wrong edge. A long randomised phase then toggles the block bit, request and boundary independently against the behavioural model.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int unsigned SR_MD_BIT   = 30;
    localparam int unsigned SR_RB_BIT   = 29;
    localparam int unsigned SR_BL_BIT   = 28;
    localparam int unsigned SR_IMASK_HI = 7;
    localparam int unsigned SR_IMASK_LO = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_ENTER = 2'd2
    } exc_state_e;
endpackage

// File: rtl/exc_entry_fsm.sv
module exc_entry_fsm
    import exc_entry_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic insn_boundary,
    input  logic blocked,
    output logic commit,
    output logic redirect
);
    exc_state_e state_q;
    exc_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state: take / hold / drop / done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_PEND: begin
                if (irq_req && !blocked) begin
                    if (insn_boundary) state_d = ST_ENTER;  // take
                    else               state_d = ST_PEND;   // hold
                end else begin
                    state_d = ST_IDLE;                      // drop
                end
            end
            ST_ENTER: state_d = ST_IDLE;                    // done
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        commit   = 1'b0;
        redirect = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_PEND: commit = irq_req && !blocked && insn_boundary;
            ST_ENTER:         redirect = 1'b1;
            default:          commit = 1'b0;
        endcase
    end

    assert_enter_on_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENTER) |-> $past(insn_boundary));

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect);

    assert_no_take_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENTER) |-> !$past(blocked));
endmodule

// File: rtl/exc_ctx_bank.sv
module exc_ctx_bank #(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CODE_W  = 12,
    parameter int unsigned NUM_EVT = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           commit,
    input  logic [XLEN-1:0]                sr_in,
    input  logic [XLEN-1:0]                pc_in,
    input  logic [CODE_W-1:0]              code_in,
    output logic [XLEN-1:0]                ssr_q,
    output logic [XLEN-1:0]                spc_q,
    output logic [NUM_EVT-1:0][CODE_W-1:0] evt_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ssr_q <= '0;
            spc_q <= '0;
        end else if (commit) begin
            ssr_q <= sr_in;
            spc_q <= pc_in;
        end
    end

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        always_ff @(posedge clk) begin
            if (!rst_n)      evt_q[g] <= '0;
            else if (commit) evt_q[g] <= code_in;
        end
    end

    for (genvar g = 1; g < NUM_EVT; g++) begin : g_evt_chk
        assert_evt_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
            evt_q[g] == evt_q[0]);
    end

    assert_save_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(commit) |-> ($stable(ssr_q) && $stable(spc_q)));
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
    import exc_entry_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter logic [31:0] VEC_OFS = 32'h0000_0600
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  logic [XLEN-1:0] sr_in,
    input  logic [XLEN-1:0] vbr_in,
    output logic [XLEN-1:0] sr_q,
    output logic [XLEN-1:0] pc_q
);
    localparam logic [XLEN-1:0] SET_MASK = (XLEN'(1) << SR_MD_BIT) |
                                           (XLEN'(1) << SR_RB_BIT) |
                                           (XLEN'(1) << SR_BL_BIT);
    localparam logic [XLEN-1:0] OFS = XLEN'(VEC_OFS);

    logic [XLEN-1:0] sr_next;
    logic [XLEN-1:0] pc_target;

    always_comb begin
        sr_next   = sr_in | SET_MASK;
        pc_target = vbr_in + OFS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
            pc_q <= '0;
        end else if (commit) begin
            sr_q <= sr_next;
            pc_q <= pc_target;
        end
    end

    assert_mask_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(commit) |-> (sr_q[SR_IMASK_HI:SR_IMASK_LO] == $past(sr_in[SR_IMASK_HI:SR_IMASK_LO])));

    assert_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(commit) |-> (pc_q == $past(vbr_in) + OFS));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CODE_W  = 12,
    parameter logic [31:0] VEC_OFS = 32'h0000_0600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic [CODE_W-1:0] irq_code,
    input  logic              insn_boundary,
    input  logic [XLEN-1:0]   sr_in,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   vbr_in,
    output logic [XLEN-1:0]   sr_out,
    output logic [XLEN-1:0]   ssr,
    output logic [XLEN-1:0]   spc,
    output logic [CODE_W-1:0] evt_a,
    output logic [CODE_W-1:0] evt_b,
    output logic [XLEN-1:0]   pc_new,
    output logic              redirect
);
    localparam int unsigned NUM_EVT = 2;

    logic                           commit;
    logic [NUM_EVT-1:0][CODE_W-1:0] evt_q;

    exc_entry_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_req       (irq_req),
        .insn_boundary (insn_boundary),
        .blocked       (sr_in[SR_BL_BIT]),
        .commit        (commit),
        .redirect      (redirect)
    );

    exc_ctx_bank #(.XLEN(XLEN), .CODE_W(CODE_W), .NUM_EVT(NUM_EVT)) u_ctx (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .sr_in   (sr_in),
        .pc_in   (pc_in),
        .code_in (irq_code),
        .ssr_q   (ssr),
        .spc_q   (spc),
        .evt_q   (evt_q)
    );

    exc_vector_unit #(.XLEN(XLEN), .VEC_OFS(VEC_OFS)) u_vec (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .sr_in  (sr_in),
        .vbr_in (vbr_in),
        .sr_q   (sr_out),
        .pc_q   (pc_new)
    );

    assign evt_a = evt_q[0];
    assign evt_b = evt_q[1];

    assert_save_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (ssr == $past(sr_in) && spc == $past(pc_in)));

    assert_load_with_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect |-> ($stable(sr_out) && $stable(pc_new) && $stable(evt_a)));

    assert_control_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (sr_out[SR_MD_BIT] && sr_out[SR_RB_BIT] && sr_out[SR_BL_BIT]));
endmodule

// File: tb/test_exc_entry_seq.sv
`timescale 1ns/1ps
module test_exc_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic [11:0] irq_code = '0;
    logic        insn_boundary = 1'b0;
    logic [31:0] sr_in = '0, pc_in = '0, vbr_in = '0;
    logic [31:0] sr_out, ssr, spc, pc_new;
    logic [11:0] evt_a, evt_b;
    logic        redirect;

    int checks = 0;
    int failures = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    exc_entry_seq i_exc_entry_seq (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_code(irq_code),
        .insn_boundary(insn_boundary), .sr_in(sr_in), .pc_in(pc_in), .vbr_in(vbr_in),
        .sr_out(sr_out), .ssr(ssr), .spc(spc), .evt_a(evt_a), .evt_b(evt_b),
        .pc_new(pc_new), .redirect(redirect)
    );

    // behavioural reference: 0 = nothing held, 1 = held, 2 = redirect cycle
    int          m_phase = 0;
    logic [31:0] m_sr = '0, m_ssr = '0, m_spc = '0, m_pc = '0;
    logic [11:0] m_evt = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_sr = '0; m_ssr = '0; m_spc = '0; m_pc = '0; m_evt = '0;
        end else if (m_phase != 2 && irq_req && !sr_in[28] && insn_boundary) begin
            m_sr  = sr_in | 32'h7000_0000;
            m_ssr = sr_in;
            m_spc = pc_in;
            m_pc  = vbr_in + 32'h600;
            m_evt = irq_code;
            m_phase = 2;
        end else if (m_phase == 2) begin
            m_phase = 0;
        end else if (irq_req && !sr_in[28]) begin
            m_phase = 1;
        end else begin
            m_phase = 0;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // compare against the model on every cycle
    always @(negedge clk) begin
        if (rst_n) begin
            chk(tag, "redirect", 32'(redirect), 32'(m_phase == 2));
            chk(tag, "sr_out", sr_out, m_sr);
            chk(tag, "ssr", ssr, m_ssr);
            chk(tag, "spc", spc, m_spc);
            chk(tag, "pc_new", pc_new, m_pc);
            chk(tag, "evt_a", 32'(evt_a), 32'(m_evt));
            chk(tag, "evt_b", 32'(evt_b), 32'(m_evt));
        end
    end

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8ns * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "redirect", 32'(redirect), 32'd0);
        chk("R1", "sr_out", sr_out, 32'd0);
        chk("R1", "evt_a", 32'(evt_a), 32'd0);
        chk("R1", "pc_new", pc_new, 32'd0);

        // R2 pending without boundary, then R3..R6 on entry
        tag = "R2";
        sr_in = 32'h0F3C_5AFF; pc_in = 32'h8000_1234; vbr_in = 32'h8C00_0000;
        irq_req = 1'b1; irq_code = 12'h3A0;
        cyc(3);
        chk("R2", "redirect no boundary", 32'(redirect), 32'd0);
        tag = "R3";
        insn_boundary = 1'b1;
        cyc();
        chk("R7", "redirect", 32'(redirect), 32'd1);
        chk("R3", "evt_a", 32'(evt_a), 32'h3A0);
        chk("R3", "evt_b", 32'(evt_b), 32'h3A0);
        chk("R4", "ssr", ssr, 32'h0F3C_5AFF);
        chk("R4", "spc", spc, 32'h8000_1234);
        chk("R5", "sr_out", sr_out, 32'h7F3C_5AFF);
        chk("R6", "pc_new", pc_new, 32'h8C00_0600);
        irq_req = 1'b0; insn_boundary = 1'b0; sr_in = sr_out;
        tag = "R7";
        cyc();
        chk("R7", "redirect one cycle", 32'(redirect), 32'd0);

        // R8 blocked requests ignored
        tag = "R8";
        irq_req = 1'b1; insn_boundary = 1'b1; irq_code = 12'h5C0;
        pc_in = 32'h1111_2222; vbr_in = 32'hFFFF_FF00;
        cyc(4);
        chk("R8", "redirect", 32'(redirect), 32'd0);
        chk("R8", "ssr unchanged", ssr, 32'h0F3C_5AFF);
        chk("R8", "evt_a unchanged", 32'(evt_a), 32'h3A0);

        // R9 withdrawn pending request
        tag = "R9";
        sr_in = 32'h0000_00A0; insn_boundary = 1'b0;
        cyc(2);
        irq_req = 1'b0;
        cyc();
        insn_boundary = 1'b1;
        cyc(2);
        chk("R9", "redirect", 32'(redirect), 32'd0);
        chk("R9", "spc unchanged", spc, 32'h8000_1234);

        // R10 request held through the redirect cycle; also R6 wrap
        tag = "R10";
        sr_in = 32'h0000_0000; irq_req = 1'b1; irq_code = 12'h111;
        cyc();
        chk("R10", "first redirect", 32'(redirect), 32'd1);
        chk("R6", "pc_new wrap", pc_new, 32'h0000_0500);
        irq_code = 12'h222; pc_in = 32'h0000_4444;
        cyc();
        chk("R10", "no back-to-back", 32'(redirect), 32'd0);
        chk("R10", "evt held", 32'(evt_a), 32'h111);
        cyc();
        chk("R10", "second redirect", 32'(redirect), 32'd1);
        chk("R10", "evt second", 32'(evt_b), 32'h222);
        irq_req = 1'b0; insn_boundary = 1'b0;
        cyc(2);

        // randomised mix against the model
        tag = "RND";
        for (int i = 0; i < 2000; i++) begin
            irq_req       = ($urandom % 3) != 0;
            insn_boundary = ($urandom % 3) == 0;
            irq_code      = 12'($urandom);
            pc_in         = $urandom;
            vbr_in        = $urandom;
            sr_in         = $urandom & ((($urandom % 4) == 0) ? 32'hFFFF_FFFF : 32'hEFFF_FFFF);
            cyc();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule